// File: doc/BRIEF.md
# Configurable Serial Frame Receiver

This block recovers characters from a single serial input line. The frame format is chosen at run time. A frame has from 5 to 9 data bits, no parity, even parity or odd parity, and one or two stop bits. The transmitter on the same link must use the same setting. Changing the format while a frame is arriving corrupts that frame, so software changes it only while the line is idle.

There are two timing modes:
- **Asynchronous mode.** A sampling tick enables the input at 16 times the bit rate. A falling line starts the search for a start bit. The receiver confirms the start bit at its centre and then samples each later bit at its centre.
- **Clocked mode.** An external bit clock arrives with the data. The receiver samples on the clock edge that a polarity input selects.

Every completed frame produces the following, all in the same cycle:
- a one-cycle valid strobe;
- the received word, aligned to bit 0;
- a frame-error flag;
- a parity-error flag.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, `rx_valid`, `rx_word`, `rx_frame_err` and `rx_parity_err` are all zero.
- R2: In asynchronous mode the receiver notices a start bit on the first sampling tick that finds the idle-high line low. It accepts the start bit only if the line is still low 8 ticks later, at mid-bit. A low pulse shorter than that produces no frame.
- R3: In asynchronous mode each later bit is taken 16 ticks after the previous sample point.
- R4: Data bits are assembled least significant bit first. The count of data bits is `cfg_data_bits`. A setting below 5 is treated as 5, and a setting above 9 is treated as 9.
- R5: When fewer than 9 data bits are configured, the bits of `rx_word` above the configured count are zero.
- R6: `cfg_parity` selects the parity mode: 2'b00 or 2'b01 means no parity, 2'b10 means even parity and 2'b11 means odd parity. With parity enabled, the bit after the last data bit is the parity bit. `rx_parity_err` is set when the data bits and the parity bit together have the wrong count of ones. With parity disabled, `rx_parity_err` is 0.
- R7: The bit after the data bits, or after the parity bit when parity is enabled, is the first stop bit. If it is sampled low, `rx_frame_err` is set. This is the only stop bit that is checked. Right after it the receiver is ready for a new start bit, so a low second stop bit does not flag the current frame and begins a new frame.
- R8: In clocked mode (`cfg_clocked`=1), bits are sampled only on edges of `ext_clk`:
  - `cfg_sample_rise`=0 samples on falling edges.
  - `cfg_sample_rise`=1 samples on rising edges.
  - A low line at a sampling edge while idle is taken as the start bit.
- R9: `rx_valid` is a single-cycle pulse for each frame. `rx_word` and both error flags change only in the cycle `rx_valid` is high and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_data_bits | input | 4 | Number of data bits, 5 to 9 (clamped) |
| cfg_parity | input | 2 | Parity mode: 0x/none, 10 even, 11 odd |
| cfg_clocked | input | 1 | 1 selects clocked sampling with `ext_clk` |
| cfg_sample_rise | input | 1 | Clocked mode: 1 samples on rising edges, 0 on falling edges |
| sample_tick | input | 1 | Asynchronous mode: enable pulse at 16x the bit rate |
| ext_clk | input | 1 | External bit clock for clocked mode |
| rx_line | input | 1 | Serial data input, idle high |
| rx_word | output | 9 | Received word, zero-extended above the data bits |
| rx_valid | output | 1 | One-cycle strobe marking a completed frame |
| rx_frame_err | output | 1 | First stop bit was low |
| rx_parity_err | output | 1 | Parity mismatch on the last frame |

## Verification
Each internal fault shows at the ports within one frame time:
- **Bit counter off by one.** The word shifts by one position, or the frame ends early, so the parity or stop check lands on a data bit. The next strobe then carries a wrong word or a spurious error.
- **Mid-bit counter wrong.** Every sample point drifts. A short start glitch is accepted as a frame instead of being ignored.
- **Wrong clock edge in clocked mode.** Data is captured before it settles, which corrupts the word of the very first frame.

Cases that change the number of frames, such as the glitch and the low second stop bit, are checked by counting strobes over a window of several bit times.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  localparam int unsigned WORD_W   = 9;
  localparam int unsigned MIN_BITS = 5;
  localparam int unsigned CNT_W    = 4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PARITY,
    S_STOP
  } rx_state_t;

  // Bring a requested data-bit count into the legal 5..9 range.
  function automatic logic [CNT_W-1:0] eff_bits(input logic [CNT_W-1:0] req);
    if (req < CNT_W'(MIN_BITS))     return CNT_W'(MIN_BITS);
    else if (req > CNT_W'(WORD_W))  return CNT_W'(WORD_W);
    else                            return req;
  endfunction

  // The shifter fills from the top; move the n received bits down to bit 0.
  function automatic logic [WORD_W-1:0] align_word(input logic [WORD_W-1:0] sr,
                                                   input logic [CNT_W-1:0]  n);
    return sr >> (CNT_W'(WORD_W) - n);
  endfunction

  // 1 when data plus parity bit have the wrong number of ones.
  function automatic logic parity_bad(input logic [WORD_W-1:0] word,
                                      input logic              pbit,
                                      input logic              odd);
    return (^word) ^ pbit ^ odd;
  endfunction

endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sfr_bit_timer.sv
module sfr_bit_timer #(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clocked,
  input  logic sample_rise,
  input  logic tick,
  input  logic ext_clk_s,
  input  logic line_s,
  input  logic hunting,
  input  logic in_start,
  output logic start_seen,
  output logic start_ok,
  output logic start_bad,
  output logic bit_stb
);
  localparam int unsigned CW = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] MID  = CW'(OVERSAMPLE/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

  logic [CW-1:0] cnt;
  logic          ext_prev;
  logic          sel_edge, at_mid, at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_prev <= 1'b0;
    else        ext_prev <= ext_clk_s;
  end

  assign sel_edge = sample_rise ? (ext_clk_s & ~ext_prev) : (~ext_clk_s & ext_prev);
  assign at_mid   = tick && (cnt == MID);
  assign at_last  = tick && (cnt == LAST);

  always_comb begin
    if (clocked) begin
      start_seen = 1'b0;
      start_ok   = hunting & sel_edge & ~line_s;
      start_bad  = 1'b0;
      bit_stb    = ~hunting & sel_edge;
    end else begin
      start_seen = hunting & tick & ~line_s;
      start_ok   = in_start & at_mid & ~line_s;
      start_bad  = in_start & at_mid & line_s;
      bit_stb    = ~hunting & ~in_start & at_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 cnt <= '0;
    else if (start_seen || start_ok || start_bad) cnt <= '0;
    else if (at_last)                           cnt <= '0;
    else if (tick)                              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sfr_frame_fsm.sv
module sfr_frame_fsm
  import sfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_data_bits,
  input  logic [1:0]        cfg_parity,
  input  logic              line_s,
  input  logic              start_seen,
  input  logic              start_ok,
  input  logic              start_bad,
  input  logic              bit_stb,
  output logic              hunting,
  output logic              in_start,
  output logic              stop_stb,
  output logic [WORD_W-1:0] word,
  output logic              valid,
  output logic              frame_err,
  output logic              parity_err
);
  rx_state_t         state;
  logic [WORD_W-1:0] sr;
  logic [CNT_W-1:0]  bitcnt;
  logic [CNT_W-1:0]  nbits;
  logic              pbit;
  logic              par_en;
  logic [WORD_W-1:0] got;

  assign nbits    = eff_bits(cfg_data_bits);
  assign par_en   = cfg_parity[1];
  assign hunting  = (state == S_IDLE);
  assign in_start = (state == S_START);
  assign stop_stb = (state == S_STOP) && bit_stb;
  assign got      = align_word(sr, nbits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      sr     <= '0;
      bitcnt <= '0;
      pbit   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start_ok) begin
            state  <= S_DATA;
            bitcnt <= '0;
          end else if (start_seen) begin
            state <= S_START;
          end
        end
        S_START: begin
          if (start_ok) begin
            state  <= S_DATA;
            bitcnt <= '0;
          end else if (start_bad) begin
            state <= S_IDLE;
          end
        end
        S_DATA: begin
          if (bit_stb) begin
            sr     <= {line_s, sr[WORD_W-1:1]};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == nbits - 1'b1) state <= par_en ? S_PARITY : S_STOP;
          end
        end
        S_PARITY: begin
          if (bit_stb) begin
            pbit  <= line_s;
            state <= S_STOP;
          end
        end
        S_STOP: begin
          if (bit_stb) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid      <= 1'b0;
      word       <= '0;
      frame_err  <= 1'b0;
      parity_err <= 1'b0;
    end else begin
      valid <= stop_stb;
      if (stop_stb) begin
        word       <= got;
        frame_err  <= ~line_s;
        parity_err <= par_en & parity_bad(got, pbit, cfg_parity[0]);
      end
    end
  end
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import sfr_pkg::*;
#(
  parameter int unsigned OVERSAMPLE  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_data_bits,
  input  logic [1:0]        cfg_parity,
  input  logic              cfg_clocked,
  input  logic              cfg_sample_rise,
  input  logic              sample_tick,
  input  logic              ext_clk,
  input  logic              rx_line,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              rx_frame_err,
  output logic              rx_parity_err
);
  logic line_s, ext_clk_s;
  logic hunting, in_start;
  logic start_seen, start_ok, start_bad, bit_stb;
  logic stop_stb;

  sfr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_line (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(line_s)
  );

  sfr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_xclk (
    .clk(clk), .rst_n(rst_n), .d(ext_clk), .q(ext_clk_s)
  );

  sfr_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .clocked(cfg_clocked), .sample_rise(cfg_sample_rise),
    .tick(sample_tick), .ext_clk_s(ext_clk_s), .line_s(line_s),
    .hunting(hunting), .in_start(in_start),
    .start_seen(start_seen), .start_ok(start_ok),
    .start_bad(start_bad), .bit_stb(bit_stb)
  );

  sfr_frame_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cfg_data_bits(cfg_data_bits), .cfg_parity(cfg_parity),
    .line_s(line_s),
    .start_seen(start_seen), .start_ok(start_ok),
    .start_bad(start_bad), .bit_stb(bit_stb),
    .hunting(hunting), .in_start(in_start), .stop_stb(stop_stb),
    .word(rx_word), .valid(rx_valid),
    .frame_err(rx_frame_err), .parity_err(rx_parity_err)
  );
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker
  import sfr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  cfg_data_bits,
  input logic [1:0]        cfg_parity,
  input logic              line_s,
  input logic              stop_stb,
  input logic [WORD_W-1:0] rx_word,
  input logic              rx_valid,
  input logic              rx_frame_err,
  input logic              rx_parity_err
);
  AST_STOP_SETS_FE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_stb |=> (rx_valid && (rx_frame_err == !$past(line_s)))); // R7

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R9

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_word) && $stable(rx_frame_err) && $stable(rx_parity_err))); // R9

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_word >> eff_bits(cfg_data_bits)) == '0)); // R5

  AST_NO_PAR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cfg_parity[1]) |-> !rx_parity_err); // R6
endmodule

bind serial_frame_rx sfr_checker u_sfr_chk (
  .clk(clk), .rst_n(rst_n),
  .cfg_data_bits(cfg_data_bits), .cfg_parity(cfg_parity),
  .line_s(line_s), .stop_stb(stop_stb),
  .rx_word(rx_word), .rx_valid(rx_valid),
  .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err)
);

// File: tb/sim_serial_frame_rx.sv
`timescale 1ns/1ps
module sim_serial_frame_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cfg_data_bits = 4'd8;
  logic [1:0] cfg_parity = 2'b00;
  logic       cfg_clocked = 1'b0;
  logic       cfg_sample_rise = 1'b0;
  logic       sample_tick = 1'b0;
  logic       ext_clk = 1'b0;
  logic       rx_line = 1'b1;
  logic [8:0] rx_word;
  logic       rx_valid, rx_frame_err, rx_parity_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_frame_rx u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_data_bits(cfg_data_bits), .cfg_parity(cfg_parity),
    .cfg_clocked(cfg_clocked), .cfg_sample_rise(cfg_sample_rise),
    .sample_tick(sample_tick), .ext_clk(ext_clk), .rx_line(rx_line),
    .rx_word(rx_word), .rx_valid(rx_valid),
    .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err)
  );

  // tick at half the clock rate: 16 ticks = 32 clocks per bit
  initial forever begin
    @(negedge clk);
    sample_tick = ~sample_tick;
  end

  // strobe monitor
  int         tot = 0;
  int         want = 0;
  logic [8:0] cap_w [2];
  logic       cap_fe [2];
  logic       cap_pe [2];
  always @(negedge clk) begin
    if (rx_valid) begin
      for (int k = 0; k < 2; k++) begin
        if (tot == want + k) begin
          cap_w[k]  = rx_word;
          cap_fe[k] = rx_frame_err;
          cap_pe[k] = rx_parity_err;
        end
      end
      tot = tot + 1;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic       clkd;
    logic       rise;
    logic [3:0] nb;
    logic [1:0] par;
    logic [8:0] data;
    logic       badp;
    logic       stop_low;
    logic       two_stop;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 4'd8,  2'b00, 9'h0A5, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 4'd5,  2'b00, 9'h1FF, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 4'd9,  2'b10, 9'h155, 1'b0, 1'b0, 1'b1},
    '{1'b0, 1'b0, 4'd7,  2'b11, 9'h05A, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b0, 4'd6,  2'b10, 9'h02C, 1'b0, 1'b1, 1'b0},
    '{1'b0, 1'b0, 4'd8,  2'b11, 9'h081, 1'b0, 1'b0, 1'b1},
    '{1'b1, 1'b0, 4'd8,  2'b00, 9'h03C, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b1, 4'd9,  2'b10, 9'h1A3, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 4'd5,  2'b11, 9'h015, 1'b0, 1'b1, 1'b0},
    '{1'b0, 1'b0, 4'd12, 2'b00, 9'h1C7, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 4'd3,  2'b10, 9'h1F6, 1'b0, 1'b0, 1'b0}
  };

  bit clk_mode = 0;
  bit rise_mode = 0;

  task automatic put_bit(input logic b);
    if (!clk_mode) begin
      rx_line = b;
      repeat (32) @(negedge clk);
    end else begin
      ext_clk = ~ext_clk;           // change edge
      repeat (4) @(negedge clk);
      rx_line = b;                  // data settles late in the half period
      repeat (4) @(negedge clk);
      ext_clk = ~ext_clk;           // sample edge
      repeat (8) @(negedge clk);
    end
  endtask

  function automatic int clampn(input int n);
    return (n < 5) ? 5 : ((n > 9) ? 9 : n);
  endfunction

  task automatic run_vec(input vec_t v, input int idx);
    int n;
    int ones;
    logic p;
    logic [8:0] expw;
    n = clampn(int'(v.nb));
    clk_mode = v.clkd;
    rise_mode = v.rise;
    cfg_clocked = v.clkd;
    cfg_sample_rise = v.rise;
    cfg_data_bits = v.nb;
    cfg_parity = v.par;
    ext_clk = v.rise;               // idle at the sample-side level
    rx_line = 1'b1;
    repeat (40) @(negedge clk);
    want = tot;
    expw = '0;
    ones = 0;
    put_bit(1'b0);
    for (int i = 0; i < n; i++) begin
      put_bit(v.data[i]);
      expw[i] = v.data[i];
      if (v.data[i]) ones++;
    end
    if (v.par[1]) begin
      p = ((ones % 2) == 1) ? ~v.par[0] : v.par[0];
      put_bit(v.badp ? ~p : p);
    end
    put_bit(v.stop_low ? 1'b0 : 1'b1);
    if (v.two_stop) put_bit(1'b1);
    rx_line = 1'b1;
    repeat (40) @(negedge clk);
    check("R9", $sformatf("vec%0d strobe count", idx), tot - want, 1);
    check(v.clkd ? "R8" : "R4", $sformatf("vec%0d word (R5 upper zero)", idx),
          int'(cap_w[0]), int'(expw));
    check("R6", $sformatf("vec%0d parity flag", idx), int'(cap_pe[0]),
          int'(v.badp & v.par[1]));
    check("R7", $sformatf("vec%0d frame flag", idx), int'(cap_fe[0]), int'(v.stop_low));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "valid after reset", int'(rx_valid), 0);
    check("R1", "word after reset", int'(rx_word), 0);
    check("R1", "flags after reset", int'({rx_frame_err, rx_parity_err}), 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R2: a short low glitch is not a start bit; R9: outputs held
    clk_mode = 0;
    cfg_clocked = 1'b0;
    cfg_data_bits = 4'd8;
    cfg_parity = 2'b00;
    rx_line = 1'b1;
    repeat (40) @(negedge clk);
    want = tot;
    rx_line = 1'b0;
    repeat (6) @(negedge clk);
    rx_line = 1'b1;
    repeat (32 * 14) @(negedge clk);
    check("R2", "glitch strobes", tot - want, 0);
    check("R9", "word held after glitch", int'(rx_word), 9'h1F6 & 9'h1F);

    // R3/R7: back-to-back frames, second stop bit low starts a new frame
    want = tot;
    put_bit(1'b0);
    for (int i = 0; i < 8; i++) put_bit(((8'h6B >> i) & 1) != 0);
    put_bit(1'b1);                  // first stop
    put_bit(1'b0);                  // second stop low = new start
    for (int i = 0; i < 8; i++) put_bit(1'b1);
    put_bit(1'b1);
    rx_line = 1'b1;
    repeat (64) @(negedge clk);
    check("R7", "rearm strobe count", tot - want, 2);
    check("R3", "first word", int'(cap_w[0]), 8'h6B);
    check("R7", "first frame flag", int'(cap_fe[0]), 0);
    check("R7", "rearm word", int'(cap_w[1]), 8'hFF);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule